// File: doc/BRIEF.md
# DDR Burst Column Address Generator

This block sits behind the command decoder of a double-data-rate memory path and turns a single column address, taken from an accepted read or write command, into the full list of column addresses for that burst. Data moves on both clock edges, so each clock cycle the block presents two column addresses: one for the rising-edge beat and one for the falling-edge beat. A valid flag marks cycles that carry a beat pair. A last flag marks the pair that holds the final beat of the burst.

The burst length (2, 4 or 8 beats) and the wrap order (sequential or interleaved) are sampled together with the command. The burst may start at any column, even or odd. The address wraps inside the aligned block of burst-length columns, and the column bits above that block never change. A burst-stop request cuts a read burst short. A new command arriving during a burst abandons the old burst and starts the new one at once. Data capture, strobe generation and latency delay lines belong to neighbouring blocks.

Top module: `colgen_burst`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `out_vld` and `out_last` are 0.
- R2: On the rising edge where `cmd_valid` is sampled high, the block registers the first beat pair: `out_vld` is 1 and `out_col_a` equals `cmd_col` in the following cycle.
- R3: `cfg_blen` selects the burst length as log2 of the beat count: 1 selects 2 beats, 2 selects 4 and 3 selects 8. Code 0 is treated as 2 beats. A full burst occupies beat-count/2 consecutive valid cycles, and `out_last` is 1 only in the final one.
- R4: With `cfg_ilv` = 0 (sequential), the low log2(BL) bits of beat i equal (start + i) mod BL. Beat 2k appears on `out_col_a` and beat 2k+1 on `out_col_b` in pair cycle k.
- R5: With `cfg_ilv` = 1 (interleaved), the low log2(BL) bits of beat i equal start XOR i.
- R6: Column bits at and above position log2(BL) equal those of the start address on every beat.
- R7: Burst length, wrap order and start address are held from the command. Changes on `cfg_blen` or `cfg_ilv` during a burst do not affect its remaining beats.
- R8: If `stop_req` is sampled high at a rising edge while a read burst still has pairs to issue, and no command arrives at that edge, the pair registered at that edge is the last one: it carries `out_last` = 1, and `out_vld` is 0 in the cycle after it.
- R9: `stop_req` has no effect during a write burst or while the block is idle.
- R10: A command sampled during a burst, including on the edge of its last pair, replaces it immediately with the new burst's first pair. When a command and `stop_req` arrive together, the command wins and the new burst runs to full length.
- R11: After a pair with `out_last` = 1, `out_vld` is 0 unless a new command was sampled on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | A read or write command is accepted this cycle |
| cmd_rd | input | 1 | 1 for a read command, 0 for a write |
| cmd_col | input | COL_W (9) | Start column of the burst |
| cfg_blen | input | LG_W (2) | Burst length code, log2 of beat count |
| cfg_ilv | input | 1 | 0 sequential wrap, 1 interleaved wrap |
| stop_req | input | 1 | Burst-stop request, acts on read bursts |
| out_vld | output | 1 | A beat pair is presented |
| out_last | output | 1 | This pair holds the final beat of the burst |
| out_col_a | output | COL_W (9) | Column of the rising-edge beat |
| out_col_b | output | COL_W (9) | Column of the falling-edge beat |

## Verification
The interesting collision is a burst-stop request and a new command landing on the same clock edge while an 8-beat read is midway. The bench raises both together after the first pair of a long read. It expects the new start column on the next pair, `out_last` low, and the new burst running to its own full length, so the command's priority is visible at the ports. A second collision places a command on the very edge that issues the previous burst's last pair. There the bench expects no idle cycle between the two bursts.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  typedef enum logic {
    ORDER_SEQ = 1'b0,
    ORDER_ILV = 1'b1
  } order_e;

  // beats in a burst for a given log2 length code
  function automatic int beats_of(input int lg);
    return 1 << lg;
  endfunction

endpackage

// File: rtl/colgen_beat_addr.sv
module colgen_beat_addr
  import colgen_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int MAX_LG = 3,
  parameter int LG_W   = 2
) (
  input  logic [COL_W-1:0]  start,
  input  logic [LG_W-1:0]   lg,
  input  order_e            order,
  input  logic [MAX_LG-1:0] beat,
  output logic [COL_W-1:0]  col
);

  logic [COL_W-1:0] wrap_mask;
  logic [COL_W-1:0] beat_ext;
  logic [COL_W-1:0] low_part;

  always_comb begin
    wrap_mask = (COL_W'(1) << lg) - COL_W'(1);
    beat_ext  = COL_W'(beat);
    if (order == ORDER_ILV) low_part = start ^ beat_ext;
    else                    low_part = start + beat_ext;
    col = (start & ~wrap_mask) | (low_part & wrap_mask);
  end

endmodule

// File: rtl/colgen_seq.sv
module colgen_seq
  import colgen_pkg::*;
#(
  parameter int MAX_LG = 3,
  parameter int LG_W   = 2,
  localparam int PAIR_W = (MAX_LG > 1) ? MAX_LG - 1 : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_go,
  input  logic              cmd_rd,
  input  logic [LG_W-1:0]   cmd_lg,
  input  logic              stop_req,
  output logic              emit,
  output logic              emit_last,
  output logic [PAIR_W-1:0] pair
);

  logic              busy_q;
  logic              rd_q;
  logic [LG_W-1:0]   lg_q;
  logic [PAIR_W-1:0] nxt_q;

  function automatic logic [PAIR_W-1:0] final_pair(input logic [LG_W-1:0] l);
    return PAIR_W'(beats_of(int'(l)) / 2 - 1);
  endfunction

  always_comb begin
    emit      = 1'b0;
    emit_last = 1'b0;
    pair      = '0;
    if (cmd_go) begin
      emit      = 1'b1;
      emit_last = (final_pair(cmd_lg) == '0);
    end else if (busy_q) begin
      emit      = 1'b1;
      pair      = nxt_q;
      emit_last = (nxt_q == final_pair(lg_q)) || (stop_req && rd_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      lg_q   <= LG_W'(1);
      nxt_q  <= '0;
    end else begin
      if (cmd_go) begin
        rd_q <= cmd_rd;
        lg_q <= cmd_lg;
      end
      busy_q <= emit && !emit_last;
      nxt_q  <= pair + PAIR_W'(1);
    end
  end

endmodule

// File: rtl/colgen_burst.sv
module colgen_burst
  import colgen_pkg::*;
#(
  parameter int COL_W  = 9,
  parameter int MAX_LG = 3,
  parameter int LG_W   = $clog2(MAX_LG + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic             cmd_rd,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [LG_W-1:0]  cfg_blen,
  input  logic             cfg_ilv,
  input  logic             stop_req,
  output logic             out_vld,
  output logic             out_last,
  output logic [COL_W-1:0] out_col_a,
  output logic [COL_W-1:0] out_col_b
);

  localparam int PAIR_W = (MAX_LG > 1) ? MAX_LG - 1 : 1;

  logic [LG_W-1:0]   cfg_lg;
  logic [COL_W-1:0]  start_q;
  logic [LG_W-1:0]   lg_q;
  order_e            order_q;
  logic [COL_W-1:0]  use_start;
  logic [LG_W-1:0]   use_lg;
  order_e            use_order;
  logic              emit;
  logic              emit_last;
  logic [PAIR_W-1:0] pair;
  logic [COL_W-1:0]  beat_col [2];

  // length code clean-up: 0 means shortest burst, too large means longest
  always_comb begin
    cfg_lg = cfg_blen;
    if (cfg_blen == '0)               cfg_lg = LG_W'(1);
    else if (int'(cfg_blen) > MAX_LG) cfg_lg = LG_W'(MAX_LG);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      lg_q    <= LG_W'(1);
      order_q <= ORDER_SEQ;
    end else if (cmd_valid) begin
      start_q <= cmd_col;
      lg_q    <= cfg_lg;
      order_q <= order_e'(cfg_ilv);
    end
  end

  // first pair comes straight from the command inputs
  always_comb begin
    use_start = cmd_valid ? cmd_col : start_q;
    use_lg    = cmd_valid ? cfg_lg : lg_q;
    use_order = cmd_valid ? order_e'(cfg_ilv) : order_q;
  end

  colgen_seq #(
    .MAX_LG(MAX_LG),
    .LG_W  (LG_W)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .cmd_go   (cmd_valid),
    .cmd_rd   (cmd_rd),
    .cmd_lg   (cfg_lg),
    .stop_req (stop_req),
    .emit     (emit),
    .emit_last(emit_last),
    .pair     (pair)
  );

  for (genvar g = 0; g < 2; g++) begin : g_edge
    colgen_beat_addr #(
      .COL_W (COL_W),
      .MAX_LG(MAX_LG),
      .LG_W  (LG_W)
    ) u_addr (
      .start(use_start),
      .lg   (use_lg),
      .order(use_order),
      .beat ({pair, 1'(g)}),
      .col  (beat_col[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld   <= 1'b0;
      out_last  <= 1'b0;
      out_col_a <= '0;
      out_col_b <= '0;
    end else begin
      out_vld  <= emit;
      out_last <= emit && emit_last;
      if (emit) begin
        out_col_a <= beat_col[0];
        out_col_b <= beat_col[1];
      end
    end
  end

endmodule

// File: rtl/colgen_chk.sv
module colgen_chk #(
  parameter int COL_W  = 9,
  parameter int MAX_LG = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_rd,
  input logic [COL_W-1:0] cmd_col,
  input logic             stop_req,
  input logic             out_vld,
  input logic             out_last,
  input logic [COL_W-1:0] out_col_a,
  input logic [COL_W-1:0] out_col_b
);

  logic rd_t;

  always_ff @(posedge clk) begin
    if (rst)            rd_t <= 1'b0;
    else if (cmd_valid) rd_t <= cmd_rd;
  end

  assert_last_has_vld_R3: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_vld);

  assert_first_beat_R2: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> (out_vld && out_col_a == $past(cmd_col)));

  assert_idle_after_last_R11: assert property (@(posedge clk) disable iff (rst)
    (out_vld && out_last && !cmd_valid) |=> !out_vld);

  assert_stop_ends_read_R8: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !out_last && stop_req && !cmd_valid && rd_t) |=> (out_vld && out_last));

  assert_upper_fixed_R6: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> ((out_col_a >> MAX_LG) == (out_col_b >> MAX_LG)));

  assert_pair_distinct_R4: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (out_col_a != out_col_b));

endmodule

bind colgen_burst colgen_chk #(
  .COL_W (COL_W),
  .MAX_LG(MAX_LG)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_valid(cmd_valid),
  .cmd_rd   (cmd_rd),
  .cmd_col  (cmd_col),
  .stop_req (stop_req),
  .out_vld  (out_vld),
  .out_last (out_last),
  .out_col_a(out_col_a),
  .out_col_b(out_col_b)
);

// File: tb/sim_colgen_burst.sv
`timescale 1ns/1ps
module sim_colgen_burst;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic       cmd_rd = 1'b0;
  logic [8:0] cmd_col = '0;
  logic [1:0] cfg_blen = 2'd1;
  logic       cfg_ilv = 1'b0;
  logic       stop_req = 1'b0;
  logic       out_vld;
  logic       out_last;
  logic [8:0] out_col_a;
  logic [8:0] out_col_b;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  colgen_burst u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_rd(cmd_rd),
    .cmd_col(cmd_col), .cfg_blen(cfg_blen), .cfg_ilv(cfg_ilv),
    .stop_req(stop_req), .out_vld(out_vld), .out_last(out_last),
    .out_col_a(out_col_a), .out_col_b(out_col_b)
  );

  function automatic logic [8:0] ecol(logic [8:0] s, int lg, bit ilv, int i);
    int bl = 1 << lg;
    int lo = int'(s) % bl;
    int nw = ilv ? (lo ^ i) : ((lo + i) % bl);
    return 9'(int'(s) - lo + nw);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_pair(string req, logic [8:0] s, int lg, bit ilv, int p, bit last);
    chk(req, "vld", 32'(out_vld), 32'd1);
    chk(req, "col_a", 32'(out_col_a), 32'(ecol(s, lg, ilv, 2 * p)));
    chk(req, "col_b", 32'(out_col_b), 32'(ecol(s, lg, ilv, 2 * p + 1)));
    chk(req, "last", 32'(out_last), 32'(last));
  endtask

  task automatic issue(logic [8:0] s, logic [1:0] code, bit ilv, bit rd);
    cmd_valid = 1'b1; cmd_col = s; cfg_blen = code; cfg_ilv = ilv; cmd_rd = rd;
  endtask

  // full burst from issue to idle; called at a falling edge
  task automatic run_burst(string req, logic [8:0] s, logic [1:0] code, bit ilv, bit rd);
    int lg = (code == 2'd0) ? 1 : int'(code);
    int np = (1 << lg) / 2;
    issue(s, code, ilv, rd);
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int p = 0; p < np; p++) begin
      if (p > 0) @(negedge clk);
      chk_pair(req, s, lg, ilv, p, p == np - 1);
    end
    @(negedge clk);
    chk({req, " R11"}, "vld after last", 32'(out_vld), 32'd0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1", "vld in reset", 32'(out_vld), 32'd0);
    chk("R1", "last in reset", 32'(out_last), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "vld after reset", 32'(out_vld), 32'd0);
  endtask

  task automatic t_orders;
    run_burst("R2 R4 R6", 9'h1F5, 2'd3, 1'b0, 1'b1);
    run_burst("R5 R6", 9'h0A3, 2'd3, 1'b1, 1'b1);
    run_burst("R4", 9'h107, 2'd2, 1'b0, 1'b0);
    run_burst("R5", 9'h0ED, 2'd2, 1'b1, 1'b0);
    run_burst("R3", 9'h031, 2'd1, 1'b0, 1'b1);
    run_burst("R3 code0", 9'h152, 2'd0, 1'b1, 1'b0);
  endtask

  task automatic t_cfg_hold;
    issue(9'h0F3, 2'd2, 1'b0, 1'b1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk_pair("R7", 9'h0F3, 2, 1'b0, 0, 1'b0);
    cfg_blen = 2'd1; cfg_ilv = 1'b1;
    @(negedge clk);
    chk_pair("R7", 9'h0F3, 2, 1'b0, 1, 1'b1);
    @(negedge clk);
    chk("R7", "vld end", 32'(out_vld), 32'd0);
  endtask

  task automatic t_stop_read;
    issue(9'h044, 2'd3, 1'b0, 1'b1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk_pair("R8", 9'h044, 3, 1'b0, 0, 1'b0);
    stop_req = 1'b1;
    @(negedge clk);
    stop_req = 1'b0;
    chk_pair("R8", 9'h044, 3, 1'b0, 1, 1'b1);
    @(negedge clk);
    chk("R8", "vld after stop", 32'(out_vld), 32'd0);
  endtask

  task automatic t_stop_ignored;
    issue(9'h1C6, 2'd2, 1'b1, 1'b0);
    stop_req = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk_pair("R9 write", 9'h1C6, 2, 1'b1, 0, 1'b0);
    @(negedge clk);
    chk_pair("R9 write", 9'h1C6, 2, 1'b1, 1, 1'b1);
    @(negedge clk);
    chk("R9", "idle vld", 32'(out_vld), 32'd0);
    @(negedge clk);
    chk("R9", "idle vld held", 32'(out_vld), 32'd0);
    stop_req = 1'b0;
  endtask

  task automatic t_restart;
    issue(9'h0B9, 2'd3, 1'b0, 1'b1);
    @(negedge clk);
    chk_pair("R10", 9'h0B9, 3, 1'b0, 0, 1'b0);
    issue(9'h12E, 2'd3, 1'b1, 1'b1);
    stop_req = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; stop_req = 1'b0;
    for (int p = 0; p < 4; p++) begin
      if (p > 0) @(negedge clk);
      chk_pair("R10 cmd over stop", 9'h12E, 3, 1'b1, p, p == 3);
    end
    // command on the same edge as the previous burst's last pair
    issue(9'h061, 2'd1, 1'b0, 1'b0);
    @(negedge clk);
    chk_pair("R10 chain", 9'h061, 1, 1'b0, 0, 1'b1);
    issue(9'h19A, 2'd2, 1'b0, 1'b1);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk_pair("R10 chain", 9'h19A, 2, 1'b0, 0, 1'b0);
    @(negedge clk);
    chk_pair("R10 chain", 9'h19A, 2, 1'b0, 1, 1'b1);
    @(negedge clk);
    chk("R11", "vld end", 32'(out_vld), 32'd0);
  endtask

  initial begin
    t_reset();
    t_orders();
    t_cfg_hold();
    t_stop_read();
    t_stop_ignored();
    t_restart();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule